// File: doc/BRIEF.md
# Flash Program and Sector-Erase Sequencer

This block is the control core of a NOR-style flash device. Bus writes arriving on active-low chip-enable, write-enable and output-enable pins are decoded into commands. A valid command starts one of two self-timed algorithms against an abstract cell-array port:

- **Word program.** The block drives a timed program pulse, reads the word back to verify it, and repeats until the cell matches.
- **Sector erase.** The block first brings every word of the sector that is not already all-zero down to zero. It then drives timed erase pulses on the whole sector and verifies, word by word, that the sector reads all ones.

While an algorithm runs, the block answers bus reads with a status word instead of array data, and it holds a ready/busy pin low. The status word has three parts:

- an inverted copy of bit 7 of the written data;
- a bit that flips on every read;
- a sticky retry-exhaustion flag.

When the algorithm finishes, the block falls back to array reads by itself. An active-low hardware reset pin aborts any algorithm at once. A low-supply input blocks all command writes.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A command write is taken only on the first cycle of a bus cycle with `ce_n` and `we_n` both low; a write with `ce_n` high has no effect on the command sequence.
- R2: Writing 0xA0 and then any address/data starts a program of that word. Each attempt holds `arr_pgm` high for PULSE_CYC cycles with address and data steady, then verifies that `arr_rdata` equals the data. Attempts repeat until the word verifies, after which `ry_by` returns high and reads with `ce_n`, `oe_n` low return `arr_rdata` at `addr`.
- R3: Writing 0x80 and then 0x30 erases the sector selected by the top SECT_W address bits. Before any erase pulse, every word of that sector that does not read 0 gets program pulses with data 0 until it does. Words that already read 0 get no pulse.
- R4: Erase then issues `arr_ers` pulses, repeating until every word of the sector reads all ones. `arr_pgm` and `arr_ers` are never high together, and no word outside the addressed sector or word changes.
- R5: While busy, bit 7 of a read returns the inverse of bit 7 of the latched program data; during an erase it returns 0.
- R6: While busy, bit 6 of a read starts at 0 after reset and changes value on each new read cycle; bits 4..0 read 0.
- R7: If MAX_PULSES pulses of one word or erase step fail to verify, no further pulses are issued. Bit 5 of a busy read then reads 1, and `ry_by` stays low until a reset.
- R8: Holding `hard_rst_n` low for one cycle ends any algorithm. By the next cycle `ry_by` is high, both strobes are low and the status bits are cleared.
- R9: While `vcc_low` is high, write cycles are ignored entirely and no algorithm starts.
- R10: Write cycles made while `ry_by` is low are ignored and leave no pending command.
- R11: After 0x80, any write whose data is not 0x30 cancels the erase sequence without starting anything.
- R12: After `rst`, `ry_by` is high, both strobes are low and `dout` is 0 while `oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_rst_n | input | 1 | Active-low abort; returns to read mode |
| vcc_low | input | 1 | Supply-low indication; blocks writes |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| dout | output | DATA_W | Read data or status word |
| ry_by | output | 1 | High when ready, low while busy |
| arr_addr | output | ADDR_W | Array word address (bus address when idle) |
| arr_wdata | output | DATA_W | Data for program pulses |
| arr_pgm | output | 1 | Program pulse strobe |
| arr_ers | output | 1 | Sector erase pulse strobe |
| arr_sector | output | SECT_W | Sector for erase pulses |
| arr_rdata | input | DATA_W | Array read data at `arr_addr` |

## Verification
The assertions check, on every cycle, the following:
- the two array strobes never overlap;
- a strobe only occurs while busy;
- the address and data stay still across a program pulse;
- the timeout flag holds busy and persists until reset;
- a hardware reset leaves the block ready;
- a low supply never lets a ready block go busy.

Only the bench scenarios can show the rest:
- the preprogram-before-erase ordering and which words received pulses;
- the number of retry pulses against a slow-to-respond array model;
- the status bits seen over successive reads;
- that commands are ignored while busy, under low supply or without chip enable.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [7:0] CODE_PROG_ARM  = 8'hA0;
    localparam logic [7:0] CODE_ERASE_ARM = 8'h80;
    localparam logic [7:0] CODE_ERASE_GO  = 8'h30;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_PROG_ARMED,
        CMD_ERASE_ARMED
    } cmd_state_t;

    typedef enum logic [3:0] {
        ALG_IDLE,
        ALG_PROG_PULSE,
        ALG_PROG_CHECK,
        ALG_PRE_SCAN,
        ALG_PRE_PULSE,
        ALG_PRE_CHECK,
        ALG_ERASE_PULSE,
        ALG_ERASE_CHECK,
        ALG_STUCK
    } alg_state_t;

    // Status byte shown on reads while an algorithm runs
    function automatic logic [7:0] status_byte(input logic data_b7,
                                               input logic toggle,
                                               input logic expired);
        return {~data_b7, toggle, expired, 5'b00000};
    endfunction

    function automatic logic is_erase_state(input alg_state_t s);
        return (s == ALG_PRE_SCAN) || (s == ALG_PRE_PULSE) || (s == ALG_PRE_CHECK) ||
               (s == ALG_ERASE_PULSE) || (s == ALG_ERASE_CHECK);
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hard_rst_n,
    input  logic       vcc_low,
    input  logic       busy,
    input  logic       wr_stb,
    input  logic [7:0] cmd_byte,
    output logic       start_prog,
    output logic       start_erase
);

    cmd_state_t state_q, state_d;
    logic       take;

    assign take = wr_stb && !busy && !vcc_low && hard_rst_n;

    always_comb begin
        state_d     = state_q;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        if (take) begin
            unique case (state_q)
                CMD_IDLE: begin
                    if (cmd_byte == CODE_PROG_ARM)
                        state_d = CMD_PROG_ARMED;
                    else if (cmd_byte == CODE_ERASE_ARM)
                        state_d = CMD_ERASE_ARMED;
                end
                CMD_PROG_ARMED: begin
                    start_prog = 1'b1;
                    state_d    = CMD_IDLE;
                end
                CMD_ERASE_ARMED: begin
                    start_erase = (cmd_byte == CODE_ERASE_GO);
                    state_d     = CMD_IDLE;
                end
                default: state_d = CMD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !hard_rst_n)
            state_q <= CMD_IDLE;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/flash_algo.sv
module flash_algo
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int SECT_W     = 4,
    parameter int PULSE_CYC  = 8,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              expired,
    output logic              data_b7,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_wdata,
    output logic              pgm_stb,
    output logic              ers_stb,
    output logic [SECT_W-1:0] op_sector
);

    localparam int WORD_W = ADDR_W - SECT_W;
    localparam int TMR_W  = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam int CNT_W  = $clog2(MAX_PULSES + 1);
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(MAX_PULSES);
    localparam logic [WORD_W-1:0] IDX_LAST  = '1;

    alg_state_t        st_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;
    logic [SECT_W-1:0] sect_q;
    logic [WORD_W-1:0] idx_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              exp_q;
    logic              spent;

    assign spent = (cnt_q == CNT_LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !hard_rst_n) begin
            st_q       <= ALG_IDLE;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            sect_q     <= '0;
            idx_q      <= '0;
            tmr_q      <= '0;
            cnt_q      <= '0;
            exp_q      <= 1'b0;
        end else begin
            unique case (st_q)
                ALG_IDLE: begin
                    tmr_q <= '0;
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (start_prog) begin
                        tgt_addr_q <= req_addr;
                        tgt_data_q <= req_data;
                        st_q       <= ALG_PROG_PULSE;
                    end else if (start_erase) begin
                        sect_q     <= req_addr[ADDR_W-1 -: SECT_W];
                        tgt_data_q <= '1;
                        st_q       <= ALG_PRE_SCAN;
                    end
                end
                ALG_PROG_PULSE, ALG_PRE_PULSE, ALG_ERASE_PULSE: begin
                    if (tmr_q == TMR_LAST) begin
                        tmr_q <= '0;
                        cnt_q <= cnt_q + 1'b1;
                        st_q  <= (st_q == ALG_PROG_PULSE) ? ALG_PROG_CHECK :
                                 (st_q == ALG_PRE_PULSE)  ? ALG_PRE_CHECK  : ALG_ERASE_CHECK;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ALG_PROG_CHECK: begin
                    if (rdata == tgt_data_q) begin
                        st_q <= ALG_IDLE;
                    end else if (spent) begin
                        st_q  <= ALG_STUCK;
                        exp_q <= 1'b1;
                    end else begin
                        st_q <= ALG_PROG_PULSE;
                    end
                end
                ALG_PRE_SCAN, ALG_PRE_CHECK: begin
                    if (rdata == '0) begin
                        cnt_q <= '0;
                        if (idx_q == IDX_LAST) begin
                            idx_q <= '0;
                            st_q  <= ALG_ERASE_PULSE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ALG_PRE_SCAN;
                        end
                    end else if (st_q == ALG_PRE_CHECK && spent) begin
                        st_q  <= ALG_STUCK;
                        exp_q <= 1'b1;
                    end else begin
                        st_q <= ALG_PRE_PULSE;
                    end
                end
                ALG_ERASE_CHECK: begin
                    if (rdata == '1) begin
                        if (idx_q == IDX_LAST)
                            st_q <= ALG_IDLE;
                        else
                            idx_q <= idx_q + 1'b1;
                    end else if (spent) begin
                        st_q  <= ALG_STUCK;
                        exp_q <= 1'b1;
                    end else begin
                        st_q <= ALG_ERASE_PULSE;
                    end
                end
                ALG_STUCK: st_q <= ALG_STUCK;
                default:   st_q <= ALG_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ALG_IDLE);
    assign expired   = exp_q;
    assign data_b7   = tgt_data_q[7];
    assign op_addr   = is_erase_state(st_q) ? {sect_q, idx_q} : tgt_addr_q;
    assign op_wdata  = is_erase_state(st_q) ? '0 : tgt_data_q;
    assign pgm_stb   = (st_q == ALG_PROG_PULSE) || (st_q == ALG_PRE_PULSE);
    assign ers_stb   = (st_q == ALG_ERASE_PULSE);
    assign op_sector = sect_q;

endmodule

// File: rtl/flash_status.sv
module flash_status
    import flash_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst_n,
    input  logic              busy,
    input  logic              expired,
    input  logic              data_b7,
    input  logic              rd_act,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout
);

    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst || !hard_rst_n)
            tog_q <= 1'b0;
        else if (rd_stb && busy)
            tog_q <= ~tog_q;
    end

    always_comb begin
        dout = '0;
        if (rd_act) begin
            if (busy)
                dout[7:0] = status_byte(data_b7, tog_q, expired);
            else
                dout = rdata;
        end
    end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int SECT_W     = 4,
    parameter int PULSE_CYC  = 8,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst_n,
    input  logic              vcc_low,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ry_by,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_pgm,
    output logic              arr_ers,
    output logic [SECT_W-1:0] arr_sector,
    input  logic [DATA_W-1:0] arr_rdata
);

    logic              wr_act, rd_act, wr_q, rd_q, wr_stb, rd_stb;
    logic              busy_w, tmo_w, b7_w, start_prog, start_erase;
    logic [ADDR_W-1:0] op_addr;

    assign wr_act = !ce_n && !we_n;
    assign rd_act = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_stb = wr_act && !wr_q;
    assign rd_stb = rd_act && !rd_q;

    flash_cmd_decode u_cmd (
        .clk        (clk),
        .rst        (rst),
        .hard_rst_n (hard_rst_n),
        .vcc_low    (vcc_low),
        .busy       (busy_w),
        .wr_stb     (wr_stb),
        .cmd_byte   (din[7:0]),
        .start_prog (start_prog),
        .start_erase(start_erase)
    );

    flash_algo #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SECT_W    (SECT_W),
        .PULSE_CYC (PULSE_CYC),
        .MAX_PULSES(MAX_PULSES)
    ) u_algo (
        .clk        (clk),
        .rst        (rst),
        .hard_rst_n (hard_rst_n),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .req_addr   (addr),
        .req_data   (din),
        .rdata      (arr_rdata),
        .busy       (busy_w),
        .expired    (tmo_w),
        .data_b7    (b7_w),
        .op_addr    (op_addr),
        .op_wdata   (arr_wdata),
        .pgm_stb    (arr_pgm),
        .ers_stb    (arr_ers),
        .op_sector  (arr_sector)
    );

    flash_status #(.DATA_W(DATA_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .hard_rst_n(hard_rst_n),
        .busy      (busy_w),
        .expired   (tmo_w),
        .data_b7   (b7_w),
        .rd_act    (rd_act),
        .rd_stb    (rd_stb),
        .rdata     (arr_rdata),
        .dout      (dout)
    );

    assign arr_addr = busy_w ? op_addr : addr;
    assign ry_by    = !busy_w;

endmodule

// File: rtl/flash_seq_ctrl_chk.sv
module flash_seq_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              hard_rst_n,
    input logic              vcc_low,
    input logic              ry_by,
    input logic              arr_pgm,
    input logic              arr_ers,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [DATA_W-1:0] arr_wdata,
    input logic              tmo
);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(arr_pgm && arr_ers)); // R4

    AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (arr_pgm || arr_ers) |-> !ry_by); // R2

    AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (arr_pgm && $past(arr_pgm)) |-> ($stable(arr_addr) && $stable(arr_wdata))); // R2

    AST_ABORT_READY: assert property (@(posedge clk) disable iff (rst)
        !hard_rst_n |=> (ry_by && !arr_pgm && !arr_ers && !tmo)); // R8

    AST_LOWVCC_NO_START: assert property (@(posedge clk) disable iff (rst)
        (ry_by && vcc_low) |=> ry_by); // R9

    AST_EXPIRED_BUSY: assert property (@(posedge clk) disable iff (rst)
        tmo |-> (!ry_by && !arr_pgm && !arr_ers)); // R7

    AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tmo && hard_rst_n) |=> tmo); // R7

endmodule

bind flash_seq_ctrl flash_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hard_rst_n(hard_rst_n),
    .vcc_low   (vcc_low),
    .ry_by     (ry_by),
    .arr_pgm   (arr_pgm),
    .arr_ers   (arr_ers),
    .arr_addr  (arr_addr),
    .arr_wdata (arr_wdata),
    .tmo       (tmo_w)
);

// File: tb/tb_flash_seq_ctrl.sv
module tb_flash_seq_ctrl;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int SW = 2;
    localparam int PC = 3;
    localparam int MP = 6;
    localparam int NW = 1 << AW;
    localparam int SWORDS = 1 << (AW - SW);

    logic clk = 1'b0, rst = 1'b1, hard_rst_n = 1'b1, vcc_low = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout, arr_wdata, arr_rdata;
    logic [AW-1:0] arr_addr;
    logic [SW-1:0] arr_sector;
    logic ry_by, arr_pgm, arr_ers;

    logic [DW-1:0] mem [NW];
    logic [DW-1:0] exp_mem [NW];
    int pulse_at [NW];
    int total = 0, bad = 0, cyc = 0;
    int pgm_resist = 0, ers_resist = 0, pgm_pulses = 0, ers_pulses = 0;
    int g_lo = 1, g_hi = 0;
    bit pgm_prev = 0, ers_prev = 0, ers_seen = 0, pgm_after_ers = 0, exp_tog = 0;

    always #5 clk = ~clk;

    assign arr_rdata = mem[arr_addr];

    flash_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .PULSE_CYC(PC), .MAX_PULSES(MP)) dut (
        .clk(clk), .rst(rst), .hard_rst_n(hard_rst_n), .vcc_low(vcc_low),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .ry_by(ry_by), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_pgm(arr_pgm),
        .arr_ers(arr_ers), .arr_sector(arr_sector), .arr_rdata(arr_rdata)
    );

    // Behavioural cell array: a pulse takes effect when it ends, after the resist count
    always @(negedge clk) begin
        if (pgm_prev && !arr_pgm && !ry_by) begin
            pgm_pulses++;
            pulse_at[arr_addr]++;
            if (pgm_resist > 0) pgm_resist--;
            else mem[arr_addr] = mem[arr_addr] & arr_wdata;
        end
        if (ers_prev && !arr_ers && !ry_by) begin
            ers_pulses++;
            if (ers_resist > 0) ers_resist--;
            else for (int i = 0; i < SWORDS; i++) mem[{arr_sector, 6'(i)}] = '1;
        end
        if (arr_ers) ers_seen = 1;
        if (arr_pgm && ers_seen) pgm_after_ers = 1;
        pgm_prev = arr_pgm;
        ers_prev = arr_ers;
    end

    // Reference comparison every clock: nothing outside the guarded range may move (R4)
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            int mism = 0;
            total++;
            for (int i = 0; i < NW; i++)
                if ((i < g_lo || i > g_hi) && mem[i] !== exp_mem[i]) mism++;
            if (mism != 0) begin
                bad++;
                $display("FAIL R4 cycle %0d: actual=%0d words changed outside target, expected=0", cyc, mism);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit use_ce = 1);
        @(negedge clk);
        addr = a; din = d; ce_n = !use_ce; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #2 d = dout;
        if (!ry_by) exp_tog = !exp_tog;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_ready(input int lim);
        int n = 0;
        while (!ry_by && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic hw_abort();
        @(negedge clk);
        hard_rst_n = 1'b0;
        @(negedge clk);
        hard_rst_n = 1'b1;
        exp_tog = 0;
    endtask

    initial begin
        logic [DW-1:0] r, r2;
        int cnt;
        for (int i = 0; i < NW; i++) begin
            mem[i] = (i % 5 == 0) ? 8'h00 : 8'(i * 37 + 11);
            exp_mem[i] = mem[i];
            pulse_at[i] = 0;
        end
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12 ry_by", 32'(ry_by), 32'd1);
        chk("R12 strobes", {30'd0, arr_pgm, arr_ers}, 32'd0);
        chk("R12 dout idle", 32'(dout), 32'd0);

        // R2: idle read returns array data
        bus_rd(8'h07, r);
        chk("R2 idle read", 32'(r), 32'(exp_mem[8'h07]));

        // R2/R5/R6/R10: program with a slow cell
        mem[8'h13] = 8'hFF; exp_mem[8'h13] = 8'hFF;
        g_lo = 8'h13; g_hi = 8'h13;
        pgm_resist = 4; pgm_pulses = 0;
        bus_wr(8'h00, 8'hA0);
        bus_wr(8'h13, 8'h4A);
        chk("R2 busy after start", 32'(ry_by), 32'd0);
        chk("R6 first toggle value", 32'(dout), 32'd0);
        bus_rd(8'h13, r);
        chk("R5 dq7 program", 32'(r[7]), 32'd1);
        chk("R6 first busy read bit6", 32'(r[6]), 32'd0);
        chk("R6 low bits zero", 32'(r[4:0]), 32'd0);
        bus_rd(8'h13, r2);
        chk("R6 toggles", 32'(r2[6]), 32'(!r[6]));
        bus_wr(8'h00, 8'hA0);
        bus_wr(8'h31, 8'h00);
        chk("R10 still in first op", 32'(ry_by), 32'd0);
        wait_ready(400);
        exp_mem[8'h13] = 8'h4A;
        chk("R2 done", 32'(ry_by), 32'd1);
        chk("R2 pulse count", 32'(pgm_pulses), 32'd5);
        bus_rd(8'h13, r);
        chk("R2 read programmed", 32'(r), 32'h4A);
        g_lo = 1; g_hi = 0;
        idle(4);
        chk("R10 no later start", 32'(ry_by), 32'd1);
        bus_rd(8'h31, r);
        chk("R10 word untouched", 32'(r), 32'(exp_mem[8'h31]));

        // R3/R4/R5: erase of sector 1
        for (int i = 0; i < NW; i++) pulse_at[i] = 0;
        pgm_resist = 0; ers_resist = 2; ers_pulses = 0; ers_seen = 0; pgm_after_ers = 0;
        g_lo = 8'h40; g_hi = 8'h7F;
        bus_wr(8'h00, 8'h80);
        bus_wr(8'h55, 8'h30);
        bus_rd(8'h00, r);
        chk("R5 dq7 erase", 32'(r[7]), 32'd0);
        chk("R6 erase bit6", 32'(r[6]), 32'(!exp_tog));
        wait_ready(3000);
        chk("R4 erase done", 32'(ry_by), 32'd1);
        cnt = 0;
        for (int i = 8'h40; i <= 8'h7F; i++)
            if (pulse_at[i] != ((exp_mem[i] == 8'h00) ? 0 : 1)) cnt++;
        chk("R3 preprogram pulses per word", 32'(cnt), 32'd0);
        chk("R3 no preprogram after erase pulse", 32'(pgm_after_ers), 32'd0);
        chk("R4 erase pulse count", 32'(ers_pulses), 32'd3);
        for (int i = 8'h40; i <= 8'h7F; i++) exp_mem[i] = 8'hFF;
        cnt = 0;
        for (int i = 8'h40; i <= 8'h7F; i++) if (mem[i] !== 8'hFF) cnt++;
        chk("R4 sector all ones", 32'(cnt), 32'd0);
        g_lo = 1; g_hi = 0;

        // R11: erase sequence cancelled by a wrong code
        bus_wr(8'h00, 8'h80);
        bus_wr(8'h01, 8'h55);
        bus_wr(8'h01, 8'h30);
        idle(3);
        chk("R11 no erase", 32'(ry_by), 32'd1);
        bus_rd(8'h01, r);
        chk("R11 data kept", 32'(r), 32'(exp_mem[8'h01]));

        // R1: write without chip enable
        bus_wr(8'h00, 8'hA0, 0);
        bus_wr(8'h32, 8'h00);
        idle(3);
        chk("R1 no start without ce", 32'(ry_by), 32'd1);

        // R9: low supply blocks writes
        vcc_low = 1'b1;
        bus_wr(8'h00, 8'hA0);
        bus_wr(8'h30, 8'h00);
        idle(3);
        chk("R9 no start low vcc", 32'(ry_by), 32'd1);
        vcc_low = 1'b0;
        bus_wr(8'h30, 8'h00);
        idle(3);
        chk("R9 arm was discarded", 32'(ry_by), 32'd1);
        bus_rd(8'h30, r);
        chk("R9 word unchanged", 32'(r), 32'(exp_mem[8'h30]));

        // R7/R8: unreachable data exhausts retries
        mem[8'h85] = 8'h00; exp_mem[8'h85] = 8'h00;
        g_lo = 8'h85; g_hi = 8'h85;
        pgm_pulses = 0;
        bus_wr(8'h00, 8'hA0);
        bus_wr(8'h85, 8'h0F);
        idle(MP * (PC + 1) + 10);
        chk("R7 stays busy", 32'(ry_by), 32'd0);
        chk("R7 pulse limit", 32'(pgm_pulses), 32'(MP));
        bus_rd(8'h85, r);
        chk("R7 dq5 set", 32'(r[5]), 32'd1);
        idle(20);
        chk("R7 no more pulses", 32'(pgm_pulses), 32'(MP));
        hw_abort();
        chk("R8 ready after abort", 32'(ry_by), 32'd1);
        bus_rd(8'h85, r);
        chk("R8 read mode after abort", 32'(r), 32'h00);
        g_lo = 1; g_hi = 0;

        // R8: abort in the middle of an erase
        g_lo = 8'h80; g_hi = 8'hBF;
        bus_wr(8'h00, 8'h80);
        bus_wr(8'h80, 8'h30);
        idle(10);
        chk("R8 erase running", 32'(ry_by), 32'd0);
        hw_abort();
        chk("R8 erase aborted", {29'd0, ry_by, arr_pgm, arr_ers}, 32'd4);
        for (int i = 8'h80; i <= 8'hBF; i++) exp_mem[i] = mem[i];
        g_lo = 1; g_hi = 0;
        bus_rd(8'h90, r);
        chk("R8 read after erase abort", 32'(r), 32'(exp_mem[8'h90]));

        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule